// File: doc/BRIEF.md
# Target Command Queue Admission Controller

This block decides whether a bus target can take a new command into its small holding queue. Each incoming request is marked as a write or a read. In the same cycle, the controller answers with either an accept or a retry. A retried master repeats the request later. A local servicing engine removes commands one at a time and says whether each removed command was a write or a read.

The queue has room for eleven commands in total, and at most one of them may be a read. While a read is waiting, only ten writes fit beside it. When no read is waiting, all eleven places may hold writes. The decision is made from the counts as they stand at the start of the cycle. A dequeue in that same cycle is recorded, but it does not make room for that cycle's request. The block keeps only occupancy counts. Command payloads and the bus signalling of the retry are handled elsewhere.

Top module: `tgt_cmd_admit`

## Requirements
- R1: While rst_ni is low, and after it is released, both counts read zero. With no request, accept_o and retry_o are low.
- R2: While req_valid_i is high, exactly one of accept_o and retry_o is high, in the same cycle. While req_valid_i is low, both are low.
- R3: A write request (req_is_read_i = 0) is accepted whenever the write count plus the read count is below 11. This lets eleven writes be queued when no read is pending.
- R4: A write request is retried when the write count plus the read count equals 11. With one read pending, this caps the writes at ten.
- R5: A read request (req_is_read_i = 1) is accepted only when the read count is 0 and the total count is below 11.
- R6: A read request is retried whenever the read count is 1, even when the total count is below 11.
- R7: An accepted request adds one to the count of its kind on the next clock edge. A retried request leaves both counts unchanged.
- R8: A dequeue (deq_valid_i, with deq_is_read_i = 1 for a read and 0 for a write) subtracts one from the count of that kind on the next clock edge. A dequeue naming a kind whose count is zero has no effect.
- R9: When an accepted request and a dequeue fall in the same cycle, both count updates take effect. The dequeue does not change that cycle's accept/retry answer.
- R10: The write count plus the read count never exceeds 11, and the read count never exceeds 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A new command request is present |
| req_is_read_i | input | 1 | Kind of request: 1 = read, 0 = write |
| deq_valid_i | input | 1 | The servicing engine removes one command |
| deq_is_read_i | input | 1 | Kind of command removed: 1 = read, 0 = write |
| accept_o | output | 1 | The request is taken into the queue this cycle |
| retry_o | output | 1 | The request must be retried |
| wr_count_o | output | 4 | Number of writes currently queued |
| rd_count_o | output | 1 | Number of reads currently queued |

## Verification
The hardest states to reach from the ports are the queue edges. One is eleven writes with no read pending. Another is ten writes beside a read, where a further request meets a dequeue in the same cycle. The bench reaches each reachable pair of counts from a fresh reset by a run of accepted enqueues. It then applies every combination of request kind, or no request, with every dequeue kind, or no dequeue. It compares the answer and the next counts with values worked out from the capacity rules.

// File: rtl/tca_pkg.sv
package tca_pkg;
  typedef enum logic {
    KIND_WRITE = 1'b0,
    KIND_READ  = 1'b1
  } cmd_kind_e;
endpackage

// File: rtl/tca_occ_counter.sv
module tca_occ_counter #(
  parameter int MAX_COUNT = 11,
  parameter int WIDTH     = $clog2(MAX_COUNT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [WIDTH-1:0] cnt_o
);
  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             dec_eff;

  // dequeue of an empty kind is dropped
  assign dec_eff = dec_i && (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    unique case ({inc_i, dec_eff})
      2'b10:   cnt_d = cnt_q + WIDTH'(1);
      2'b01:   cnt_d = cnt_q - WIDTH'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_cnt_cap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= MAX_COUNT);

  assert_empty_dec_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/tca_admit_logic.sv
module tca_admit_logic #(
  parameter int TOTAL_DEPTH = 11,
  parameter int READ_SLOTS  = 1,
  parameter int WR_W        = 4,
  parameter int RD_W        = 1
) (
  input  logic            req_valid_i,
  input  tca_pkg::cmd_kind_e req_kind_i,
  input  logic [WR_W-1:0] wr_cnt_i,
  input  logic [RD_W-1:0] rd_cnt_i,
  output logic            accept_o,
  output logic            retry_o,
  output logic            wr_inc_o,
  output logic            rd_inc_o
);
  import tca_pkg::*;
  localparam int SUM_W = WR_W + 1;

  logic [SUM_W-1:0] total;
  logic             room_total;
  logic             room_read;
  logic             fits;

  assign total      = SUM_W'(wr_cnt_i) + SUM_W'(rd_cnt_i);
  assign room_total = int'(total) < TOTAL_DEPTH;
  assign room_read  = int'(rd_cnt_i) < READ_SLOTS;

  always_comb begin
    unique case (req_kind_i)
      KIND_READ: fits = room_total && room_read;
      default:   fits = room_total;
    endcase
  end

  assign accept_o = req_valid_i && fits;
  assign retry_o  = req_valid_i && !fits;
  assign wr_inc_o = accept_o && (req_kind_i == KIND_WRITE);
  assign rd_inc_o = accept_o && (req_kind_i == KIND_READ);
endmodule

// File: rtl/tgt_cmd_admit.sv
module tgt_cmd_admit #(
  parameter int TOTAL_DEPTH = 11,
  parameter int READ_SLOTS  = 1,
  parameter int WR_W        = $clog2(TOTAL_DEPTH + 1),
  parameter int RD_W        = $clog2(READ_SLOTS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic            req_is_read_i,
  input  logic            deq_valid_i,
  input  logic            deq_is_read_i,
  output logic            accept_o,
  output logic            retry_o,
  output logic [WR_W-1:0] wr_count_o,
  output logic [RD_W-1:0] rd_count_o
);
  import tca_pkg::*;
  localparam int SUM_W = WR_W + 1;

  cmd_kind_e        req_kind;
  logic             wr_inc, rd_inc;
  logic             wr_dec, rd_dec;
  logic [WR_W-1:0]  wr_cnt;
  logic [RD_W-1:0]  rd_cnt;
  logic [SUM_W-1:0] total;

  assign req_kind = cmd_kind_e'(req_is_read_i);
  assign wr_dec   = deq_valid_i && !deq_is_read_i;
  assign rd_dec   = deq_valid_i &&  deq_is_read_i;

  tca_admit_logic #(
    .TOTAL_DEPTH(TOTAL_DEPTH), .READ_SLOTS(READ_SLOTS), .WR_W(WR_W), .RD_W(RD_W)
  ) i_admit (
    .req_valid_i(req_valid_i),
    .req_kind_i (req_kind),
    .wr_cnt_i   (wr_cnt),
    .rd_cnt_i   (rd_cnt),
    .accept_o   (accept_o),
    .retry_o    (retry_o),
    .wr_inc_o   (wr_inc),
    .rd_inc_o   (rd_inc)
  );

  tca_occ_counter #(.MAX_COUNT(TOTAL_DEPTH), .WIDTH(WR_W)) i_wr_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(wr_inc), .dec_i(wr_dec), .cnt_o(wr_cnt)
  );

  tca_occ_counter #(.MAX_COUNT(READ_SLOTS), .WIDTH(RD_W)) i_rd_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(rd_inc), .dec_i(rd_dec), .cnt_o(rd_cnt)
  );

  assign wr_count_o = wr_cnt;
  assign rd_count_o = rd_cnt;
  assign total      = SUM_W'(wr_cnt) + SUM_W'(rd_cnt);

  assert_total_cap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(total) <= TOTAL_DEPTH);

  assert_resp_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $onehot({accept_o, retry_o}));

  assert_no_resp_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !(accept_o || retry_o));

  assert_full_retry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && int'(total) == TOTAL_DEPTH) |-> retry_o);

  assert_second_read_retry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_is_read_i && int'(rd_count_o) == READ_SLOTS) |-> retry_o);

  assert_retry_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_o && !deq_valid_i) |=> ($stable(wr_count_o) && $stable(rd_count_o)));
endmodule

// File: tb/test_tgt_cmd_admit.sv
module test_tgt_cmd_admit;
  localparam int TOTAL = 11;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_valid_i = 1'b0, req_is_read_i = 1'b0;
  logic       deq_valid_i = 1'b0, deq_is_read_i = 1'b0;
  logic       accept_o, retry_o;
  logic [3:0] wr_count_o;
  logic [0:0] rd_count_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  tgt_cmd_admit i_tgt_cmd_admit (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_is_read_i(req_is_read_i),
    .deq_valid_i(deq_valid_i), .deq_is_read_i(deq_is_read_i),
    .accept_o(accept_o), .retry_o(retry_o),
    .wr_count_o(wr_count_o), .rd_count_o(rd_count_o)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // drive at negedge, sample comb outputs, then let the edge pass
  task automatic step(bit req, bit rd, bit dq, bit dqrd, output bit acc, output bit rty);
    @(negedge clk_i);
    req_valid_i = req; req_is_read_i = rd;
    deq_valid_i = dq;  deq_is_read_i = dqrd;
    #1;
    acc = accept_o; rty = retry_o;
    @(posedge clk_i);
    #1;
    req_valid_i = 1'b0; deq_valid_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    #3;
    check("R1", "wr_count in reset", int'(wr_count_o), 0);
    check("R1", "rd_count in reset", int'(rd_count_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit a, t;
    do_reset();
    #1;
    check("R1", "accept idle after reset", int'(accept_o), 0);
    check("R1", "retry idle after reset", int'(retry_o), 0);

    for (int w = 0; w <= TOTAL; w++) begin
      for (int r = 0; r <= 1; r++) begin
        if (w + r > TOTAL) continue;
        for (int req = 0; req < 3; req++) begin
          for (int dq = 0; dq < 3; dq++) begin
            int  tot;
            bit  exp_acc;
            int  exp_w, exp_r;
            string tag, ctag;
            do_reset();
            for (int k = 0; k < r; k++) step(1'b1, 1'b1, 1'b0, 1'b0, a, t);
            for (int k = 0; k < w; k++) step(1'b1, 1'b0, 1'b0, 1'b0, a, t);
            check("R3", "fill wr_count", int'(wr_count_o), w);
            check("R5", "fill rd_count", int'(rd_count_o), r);
            tot = w + r;
            if (req == 0) begin
              exp_acc = 1'b0; tag = "R2";
            end else if (req == 2) begin
              exp_acc = (tot < TOTAL) && (r == 0);
              tag = (r == 1) ? "R6" : "R5";
            end else begin
              exp_acc = (tot < TOTAL);
              tag = (tot >= TOTAL) ? "R4" : "R3";
            end
            exp_w = w + ((exp_acc && req == 1) ? 1 : 0) - ((dq == 1 && w > 0) ? 1 : 0);
            exp_r = r + ((exp_acc && req == 2) ? 1 : 0) - ((dq == 2 && r > 0) ? 1 : 0);
            if (dq != 0 && exp_acc) ctag = "R9";
            else if (dq != 0)       ctag = "R8";
            else                    ctag = "R7";
            step(req != 0, req == 2, dq != 0, dq == 2, a, t);
            check(tag, "accept", int'(a), int'(exp_acc));
            check((req == 0) ? "R2" : tag, "retry", int'(t), int'((req != 0) && !exp_acc));
            check(ctag, "wr_count after", int'(wr_count_o), exp_w);
            check(ctag, "rd_count after", int'(rd_count_o), exp_r);
            check("R10", "total cap", int'(((int'(wr_count_o) + int'(rd_count_o)) <= TOTAL)), 1);
          end
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule